// File: doc/BRIEF.md
# Boost Converter Soft-Start and Fault Sequencer

This block brings up a boost converter in timed steps once its active-low enable is pulled low. First the input disconnect switch runs as a limited current source to pre-charge the output. Next the switch turns fully on. Switching then starts with the current limit stepped up from a quarter of full scale to three quarters, and the sequence ends in a steady normal state at full limit. Every stage is timed by counting pulses of a free-running 1 µs tick, so the clock frequency does not affect the timing.

Four digital fault flags are monitored: input undervoltage, input-switch overcurrent, output overvoltage and over-temperature. Each fault class has its own reaction. An overcurrent restarts the sequence at once. Undervoltage holds everything off until the flag drops. Overvoltage and over-temperature hold off until their own recovery flag pulses. All outputs are decoded from the registered state, so a sampled input affects the outputs one clock later.

Top module: `boost_seq`

## Requirements
- R1: After reset, and whenever the block is disabled, sw_mode_o = 0 (switch open), sw_en_o = 0 and ilim_o = 0. The sw_mode_o codes are 0 = open, 1 = limited current source, 2 = fully on; code 3 never appears.
- R2: The clock after en_ni is sampled low, the block enters soft inrush: sw_mode_o = 1, sw_en_o = 0, ilim_o = 0. It stays there for 2048 tick pulses.
- R3: The switch-enable stage follows soft inrush: sw_mode_o = 2, sw_en_o = 0. It lasts 128 tick pulses.
- R4: Three soft-boost stages follow, each lasting 2048 tick pulses, with sw_mode_o = 2 and sw_en_o = 1. ilim_o is 0, 1, then 2 (the codes for 25 %, 50 % and 75 % of full scale).
- R5: After the third soft-boost stage the block enters normal: sw_mode_o = 2, sw_en_o = 1, ilim_o = 3 (100 %). It stays there with no time limit.
- R6: Stage timers advance only on clock edges where tick_i is high. Edges with tick_i low change nothing.
- R7: en_ni sampled high in any state opens the switch and stops switching on the next clock (R1 outputs). A later low en_ni restarts from soft inrush.
- R8: uv_i sampled high while enabled forces the R1 outputs on the next clock. The outputs stay off while uv_i is high. The clock after uv_i is sampled low, soft inrush starts.
- R9: oc_i sampled high in any running stage after soft inrush restarts soft inrush on the next clock, with its timer cleared. oc_i has no effect during soft inrush.
- R10: ov_i sampled high while running forces the R1 outputs on the next clock. The block then waits, ignoring ov_i, until ov_clr_i is sampled high, and restarts soft inrush on the clock after that.
- R11: ot_i sampled high while running, or while waiting on overvoltage, forces the R1 outputs. The block then waits until ot_clr_i is sampled high, and restarts soft inrush on the clock after that.
- R12: When several faults are seen at once, the priority is undervoltage, then over-temperature, then overvoltage, then overcurrent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse every microsecond |
| en_ni | input | 1 | Enable, active low |
| uv_i | input | 1 | Input undervoltage flag |
| oc_i | input | 1 | Input-switch overcurrent flag |
| ov_i | input | 1 | Output overvoltage flag |
| ov_clr_i | input | 1 | Overvoltage recovered |
| ot_i | input | 1 | Over-temperature flag |
| ot_clr_i | input | 1 | Temperature recovered |
| sw_mode_o | output | 2 | Input switch mode: 0 open, 1 current source, 2 full on |
| sw_en_o | output | 1 | Switching enable |
| ilim_o | output | 2 | Current-limit code: 0 25 %, 1 50 %, 2 75 %, 3 100 % |

## Verification
The bench targets these corner cases:
- An overcurrent pulse inside soft inrush. A design that does not mask it would restart endlessly and never leave pre-charge.
- Overcurrent in a soft-boost stage. A design that does not clear the timer on restart would come back with a shortened inrush.
- All four faults raised together, then removed one at a time. This exposes a wrong priority order, and a recovery flag that is wrongly honoured while a higher-priority wait is in force.
- A slowed tick. A design that counts clocks instead of ticks would reach normal three times too early.

// File: rtl/boost_seq_pkg.sv
package boost_seq_pkg;

  typedef enum logic [3:0] {
    ST_OFF, ST_INRUSH, ST_SWEN, ST_SB25, ST_SB50, ST_SB75, ST_NORMAL,
    ST_WAIT_UV, ST_WAIT_OV, ST_WAIT_OT
  } seq_state_e;

  typedef enum logic [1:0] {
    SW_OPEN  = 2'd0,
    SW_LIMIT = 2'd1,
    SW_FULL  = 2'd2
  } sw_mode_e;

  // fault request bit positions, lower index wins
  localparam int FLT_UV  = 0;
  localparam int FLT_OT  = 1;
  localparam int FLT_OV  = 2;
  localparam int FLT_OC  = 3;
  localparam int NUM_FLT = 4;

  function automatic seq_state_e next_stage(seq_state_e s);
    unique case (s)
      ST_INRUSH: return ST_SWEN;
      ST_SWEN:   return ST_SB25;
      ST_SB25:   return ST_SB50;
      ST_SB50:   return ST_SB75;
      default:   return ST_NORMAL;
    endcase
  endfunction

  function automatic logic is_running(seq_state_e s);
    return (s == ST_INRUSH) || (s == ST_SWEN) || (s == ST_SB25) ||
           (s == ST_SB50) || (s == ST_SB75) || (s == ST_NORMAL);
  endfunction

endpackage

// File: rtl/seq_fault_arb.sv
module seq_fault_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o
);
  assign grant_o[0] = req_i[0];
  for (genvar i = 1; i < N; i++) begin : g_pri
    assign grant_o[i] = req_i[i] & ~(|req_i[i-1:0]);
  end
endmodule

// File: rtl/seq_tick_timer.sv
module seq_tick_timer #(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = tick_i && (cnt_q == CW'(limit_i - 1'b1));
endmodule

// File: rtl/seq_out_dec.sv
module seq_out_dec
  import boost_seq_pkg::*;
(
  input  seq_state_e st_i,
  output logic [1:0] sw_mode_o,
  output logic       sw_en_o,
  output logic [1:0] ilim_o
);
  always_comb begin
    sw_mode_o = SW_OPEN;
    sw_en_o   = 1'b0;
    ilim_o    = 2'd0;
    unique case (st_i)
      ST_INRUSH: sw_mode_o = SW_LIMIT;
      ST_SWEN:   sw_mode_o = SW_FULL;
      ST_SB25:   begin sw_mode_o = SW_FULL; sw_en_o = 1'b1; ilim_o = 2'd0; end
      ST_SB50:   begin sw_mode_o = SW_FULL; sw_en_o = 1'b1; ilim_o = 2'd1; end
      ST_SB75:   begin sw_mode_o = SW_FULL; sw_en_o = 1'b1; ilim_o = 2'd2; end
      ST_NORMAL: begin sw_mode_o = SW_FULL; sw_en_o = 1'b1; ilim_o = 2'd3; end
      default: ;
    endcase
  end
endmodule

// File: rtl/boost_seq.sv
module boost_seq
  import boost_seq_pkg::*;
#(
  parameter int INRUSH_TICKS = 2048,
  parameter int SWEN_TICKS   = 128,
  parameter int BOOST_TICKS  = 2048
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       en_ni,
  input  logic       uv_i,
  input  logic       oc_i,
  input  logic       ov_i,
  input  logic       ov_clr_i,
  input  logic       ot_i,
  input  logic       ot_clr_i,
  output logic [1:0] sw_mode_o,
  output logic       sw_en_o,
  output logic [1:0] ilim_o
);
  localparam int MAX_A = (INRUSH_TICKS > BOOST_TICKS) ? INRUSH_TICKS : BOOST_TICKS;
  localparam int MAX_T = (MAX_A > SWEN_TICKS) ? MAX_A : SWEN_TICKS;
  localparam int CW    = $clog2(MAX_T + 1);
  localparam logic [CW-1:0] LIM_INRUSH = CW'(INRUSH_TICKS);
  localparam logic [CW-1:0] LIM_SWEN   = CW'(SWEN_TICKS);
  localparam logic [CW-1:0] LIM_BOOST  = CW'(BOOST_TICKS);

  seq_state_e         st_q, st_d;
  logic [NUM_FLT-1:0] flt_req, flt_gnt;
  logic [CW-1:0]      limit;
  logic               stage_done;

  // overcurrent masked while pre-charging
  always_comb begin
    flt_req         = '0;
    flt_req[FLT_UV] = uv_i;
    flt_req[FLT_OT] = ot_i;
    flt_req[FLT_OV] = ov_i;
    flt_req[FLT_OC] = oc_i && (st_q != ST_INRUSH);
  end

  seq_fault_arb #(.N(NUM_FLT)) u_arb (
    .req_i   (flt_req),
    .grant_o (flt_gnt)
  );

  always_comb begin
    unique case (st_q)
      ST_INRUSH: limit = LIM_INRUSH;
      ST_SWEN:   limit = LIM_SWEN;
      default:   limit = LIM_BOOST;
    endcase
  end

  seq_tick_timer #(.CW(CW)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (st_d != st_q),
    .tick_i  (tick_i),
    .limit_i (limit),
    .done_o  (stage_done)
  );

  always_comb begin
    st_d = st_q;
    if (en_ni)                st_d = ST_OFF;
    else if (flt_gnt[FLT_UV]) st_d = ST_WAIT_UV;
    else begin
      unique case (st_q)
        ST_OFF, ST_WAIT_UV: st_d = ST_INRUSH;
        ST_WAIT_OT: if (ot_clr_i) st_d = ST_INRUSH;
        ST_WAIT_OV: begin
          if (flt_gnt[FLT_OT]) st_d = ST_WAIT_OT;
          else if (ov_clr_i)   st_d = ST_INRUSH;
        end
        default: begin
          if (flt_gnt[FLT_OT])      st_d = ST_WAIT_OT;
          else if (flt_gnt[FLT_OV]) st_d = ST_WAIT_OV;
          else if (flt_gnt[FLT_OC]) st_d = ST_INRUSH;
          else if (stage_done && st_q != ST_NORMAL) st_d = next_stage(st_q);
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_OFF;
    else         st_q <= st_d;
  end

  seq_out_dec u_dec (
    .st_i      (st_q),
    .sw_mode_o (sw_mode_o),
    .sw_en_o   (sw_en_o),
    .ilim_o    (ilim_o)
  );
endmodule

// File: rtl/boost_seq_chk.sv
module boost_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       en_ni,
  input logic       uv_i,
  input logic       oc_i,
  input logic       ov_i,
  input logic       ot_i,
  input logic [1:0] sw_mode_o,
  input logic       sw_en_o,
  input logic [1:0] ilim_o
);
  p_mode_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_mode_o != 2'd3);

  p_inrush_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_mode_o == 2'd1) |-> (!sw_en_o && ilim_o == 2'd0));

  p_ilim_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_en_o && $past(sw_en_o) && ilim_o != $past(ilim_o)) |-> (ilim_o == $past(ilim_o) + 2'd1));

  p_no_tick_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_en_o && !tick_i && !en_ni && !uv_i && !ot_i && !ov_i && !oc_i) |=> (sw_en_o && $stable(ilim_o)));

  p_disable_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_ni |=> (sw_mode_o == 2'd0 && !sw_en_o));

  p_uv_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_ni && uv_i) |=> (sw_mode_o == 2'd0 && !sw_en_o));

  p_oc_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_en_o && !en_ni && !uv_i && !ot_i && !ov_i && oc_i) |=> (sw_mode_o == 2'd1 && !sw_en_o));

  p_ov_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_mode_o != 2'd0 && !en_ni && ov_i) |=> (sw_mode_o == 2'd0 && !sw_en_o));

  p_ot_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_mode_o != 2'd0 && !en_ni && ot_i) |=> (sw_mode_o == 2'd0 && !sw_en_o));
endmodule

bind boost_seq boost_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .en_ni     (en_ni),
  .uv_i      (uv_i),
  .oc_i      (oc_i),
  .ov_i      (ov_i),
  .ot_i      (ot_i),
  .sw_mode_o (sw_mode_o),
  .sw_en_o   (sw_en_o),
  .ilim_o    (ilim_o)
);

// File: tb/boost_seq_test.sv
`timescale 1ns/1ps
module boost_seq_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic en_ni = 1'b1;
  logic uv_i = 1'b0, oc_i = 1'b0, ov_i = 1'b0, ov_clr_i = 1'b0, ot_i = 1'b0, ot_clr_i = 1'b0;
  logic [1:0] sw_mode_o, ilim_o;
  logic       sw_en_o;

  boost_seq uut (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0, tick_div = 1, tick_cnt = 0;
  string cur_tag = "R1";
  bit done = 0;

  // reference: mode 0 off, 1 running, 2 wait uv, 3 wait ov, 4 wait ot
  int mode = 0, el = 0;
  localparam int T_INR = 2048, T_SW = 128, T_SB = 2048;
  localparam int T_END = T_INR + T_SW + 3 * T_SB;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode = 0; el = 0;
    end else if (en_ni) begin
      mode = 0; el = 0;
    end else if (uv_i) begin
      mode = 2; el = 0;
    end else begin
      case (mode)
        0, 2: begin mode = 1; el = 0; end
        3: if (ot_i) mode = 4; else if (ov_clr_i) begin mode = 1; el = 0; end
        4: if (ot_clr_i) begin mode = 1; el = 0; end
        default: begin
          if (ot_i) mode = 4;
          else if (ov_i) mode = 3;
          else if (oc_i && el >= T_INR) el = 0;
          else if (tick_i && el < T_END) el++;
        end
      endcase
    end
  end

  always @(negedge clk_i) begin
    int esw, een, eil;
    string tg;
    esw = 0; een = 0; eil = 0; tg = cur_tag;
    if (mode == 1) begin
      if (el < T_INR) begin esw = 1; tg = "R2"; end
      else if (el < T_INR + T_SW) begin esw = 2; tg = "R3"; end
      else begin
        esw = 2; een = 1;
        eil = (el - T_INR - T_SW) / T_SB;
        if (eil > 3) eil = 3;
        tg = (eil == 3) ? "R5" : "R4";
      end
    end
    n_chk++;
    if (sw_mode_o !== esw[1:0] || sw_en_o !== een[0] || ilim_o !== eil[1:0]) begin
      n_fail++;
      $display("FAIL %s/%s cyc %0d: got mode=%0d en=%0d ilim=%0d exp mode=%0d en=%0d ilim=%0d",
               tg, cur_tag, cyc, sw_mode_o, sw_en_o, ilim_o, esw, een, eil);
    end
    tick_i = (tick_cnt % tick_div) == 0;
    tick_cnt++;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc >= 190000 && !done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout exp finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    wait_n(3);
    rst_ni = 1'b1;
    cur_tag = "R1"; wait_n(10);
    // full bring-up, then hold in normal
    cur_tag = "R5"; en_ni = 1'b0; wait_n(8400);
    // overcurrent: restart, ignored in inrush, restart from soft boost
    cur_tag = "R9"; oc_i = 1; wait_n(1); oc_i = 0; wait_n(100);
    oc_i = 1; wait_n(3); oc_i = 0; wait_n(2900);
    oc_i = 1; wait_n(1); oc_i = 0; wait_n(50);
    cur_tag = "R7"; en_ni = 1; wait_n(5); en_ni = 0; wait_n(2200);
    cur_tag = "R10"; ov_i = 1; wait_n(4); ov_i = 0; wait_n(20);
    ov_clr_i = 1; wait_n(1); ov_clr_i = 0; wait_n(2500);
    cur_tag = "R11"; ot_i = 1; wait_n(3); ot_i = 0; wait_n(10);
    ot_clr_i = 1; wait_n(1); ot_clr_i = 0; wait_n(100);
    // all faults at once, removed in order
    cur_tag = "R12"; uv_i = 1; ot_i = 1; ov_i = 1; oc_i = 1; wait_n(5);
    uv_i = 0; wait_n(5); oc_i = 0; ot_i = 0; wait_n(3);
    ot_clr_i = 1; wait_n(1); ot_clr_i = 0; wait_n(5);
    ov_i = 0; ov_clr_i = 1; wait_n(1); ov_clr_i = 0; wait_n(20);
    ov_i = 1; wait_n(2); ov_i = 0; ot_i = 1; wait_n(2); ot_i = 0;
    ov_clr_i = 1; wait_n(1); ov_clr_i = 0; wait_n(5);
    ot_clr_i = 1; wait_n(1); ot_clr_i = 0; wait_n(50);
    cur_tag = "R8"; wait_n(8400); uv_i = 1; wait_n(30); uv_i = 0; wait_n(100);
    cur_tag = "R6"; en_ni = 1; wait_n(2); tick_div = 3; en_ni = 0; wait_n(26000);
    tick_div = 1; wait_n(10);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule